// File: doc/BRIEF.md
# Buffered Transmit-Only Parallel Sample Link

This block sends 32-bit sample words out of a chip over a synchronous, one-way parallel link. Words are written into a local FIFO through a simple write strobe. The FIFO holds up to `DEPTH` words. The link side forwards the core clock as the bus clock. It raises a request line while words are waiting. It drives a beat only after the far end has answered with acknowledge.

In the default narrow mode, each stored word leaves as two 16-bit beats on the low lane, low half-word first. A word leaves the FIFO only after its second beat. A pause in acknowledge between the two beats is harmless, because the pending half is kept and sent on resumption. In wide mode, both lanes carry the whole word in a single beat.

Three status outputs report the FIFO condition: full, empty, and a sticky overflow flag for writes that had to be dropped.

Top module: `burst_link_tx`

## Requirements
- R1: While reset is held, and on the first cycle after it, request and write enable are low, empty is high, full is low and overflow is low.
- R2: Request is high exactly when the FIFO holds at least one word, and empty is its inverse.
- R3: A write arriving while the FIFO holds `DEPTH` words is discarded and sets overflow, which then stays high until reset.
- R4: Full is high exactly when the FIFO holds `DEPTH` words.
- R5: Write enable is high in a cycle only if acknowledge and request were both high at the preceding rising clock edge.
- R6: In narrow mode (`wide_mode` = 0), a word is sent as two beats: bits [15:0] first, then bits [31:16]. Each beat appears on `bus_data[15:0]`, and `bus_data[31:16]` reads zero.
- R7: In narrow mode, a word stays in the FIFO until its second beat is sent. If acknowledge is low between the two beats, the next beat sent is the pending upper half.
- R8: In wide mode (`wide_mode` = 1), each word is sent whole on `bus_data[31:0]` in one beat and is then removed.
- R9: Words leave in the order they were written.
- R10: A beat is registered: it appears on `bus_wen`/`bus_data` in the cycle after the rising edge at which acknowledge was high with a word waiting.
- R11: `bus_clk` is the core clock passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also forwarded as the bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the FIFO |
| wr_data | input | 32 | Word to buffer |
| wide_mode | input | 1 | 1: one 32-bit beat per word; 0: two 16-bit beats |
| bus_ack | input | 1 | Acknowledge from the receiver |
| bus_clk | output | 1 | Forwarded bus clock |
| bus_req | output | 1 | Request: words are waiting |
| bus_wen | output | 1 | Write enable: a valid beat is on the data lines |
| bus_data | output | 32 | Beat data (only [15:0] used in narrow mode) |
| full | output | 1 | FIFO holds DEPTH words |
| empty | output | 1 | FIFO holds no word |
| overflow | output | 1 | Sticky: a write was dropped because the FIFO was full |

## Verification
The assertions assume that `wide_mode` changes only while the FIFO is empty, so that no word is ever half sent. They also assume that acknowledge is synchronous to the core clock, and that `DEPTH` is a power of two so the pointers wrap on their own.

The stimulus keeps to these rules. It waits until the FIFO has drained, checked through the empty output, before it switches mode. It drives acknowledge and the write strobe only at falling edges. Within those limits, acknowledge is toggled freely, including between the two halves of a word and while the FIFO is completely full.

// File: rtl/burst_link_tx.sv
module burst_link_tx #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wide_mode,
  input  logic              bus_ack,
  output logic              bus_clk,
  output logic              bus_req,
  output logic              bus_wen,
  output logic [DATA_W-1:0] bus_data,
  output logic              full,
  output logic              empty,
  output logic              overflow
);
  localparam int LANE_W = DATA_W / 2;
  localparam int AW     = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = DEPTH;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [AW:0]       count;
  logic              upper_pending;
  logic [DATA_W-1:0] head;
  logic              push, beat, pop;

  assign bus_clk = clk;
  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign bus_req = !empty;
  assign head    = mem[rd_ptr];
  assign push    = wr_en && !full;
  assign beat    = bus_ack && !empty;
  assign pop     = beat && (wide_mode || upper_pending);

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_en && full) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_wen       <= 1'b0;
      bus_data      <= '0;
      upper_pending <= 1'b0;
    end else begin
      bus_wen <= beat;
      if (beat) begin
        if (wide_mode) begin
          bus_data      <= head;
          upper_pending <= 1'b0;
        end else if (upper_pending) begin
          bus_data      <= {{LANE_W{1'b0}}, head[DATA_W-1:LANE_W]};
          upper_pending <= 1'b0;
        end else begin
          bus_data      <= {{LANE_W{1'b0}}, head[LANE_W-1:0]};
          upper_pending <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/burst_link_tx_checks.sv
module burst_link_tx_checks #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wide_mode,
  input logic              bus_ack,
  input logic              bus_req,
  input logic              bus_wen,
  input logic [DATA_W-1:0] bus_data,
  input logic              full,
  input logic              empty,
  input logic              overflow
);
  localparam int LANE_W = DATA_W / 2;

  p_wen_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wen |-> $past(bus_ack));

  p_wen_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wen |-> $past(bus_req));

  p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_overflow_on_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> overflow);

  p_full_not_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !empty);

  p_narrow_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && !$past(wide_mode)) |-> (bus_data[DATA_W-1:LANE_W] == '0));

  p_empty_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr_en) |=> empty);
endmodule

bind burst_link_tx burst_link_tx_checks #(.DATA_W(DATA_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wide_mode(wide_mode),
  .bus_ack(bus_ack), .bus_req(bus_req), .bus_wen(bus_wen),
  .bus_data(bus_data), .full(full), .empty(empty), .overflow(overflow)
);

// File: tb/burst_link_tx_test.sv
module burst_link_tx_test;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wide_mode = 1'b0;
  logic        bus_ack = 1'b0;
  logic        bus_clk, bus_req, bus_wen, full, empty, overflow;
  logic [31:0] bus_data;

  burst_link_tx #(.DATA_W(32), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wide_mode(wide_mode), .bus_ack(bus_ack), .bus_clk(bus_clk),
    .bus_req(bus_req), .bus_wen(bus_wen), .bus_data(bus_data),
    .full(full), .empty(empty), .overflow(overflow)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;
  bit live = 0;

  logic [31:0] q[$];
  bit          m_half = 0;
  bit          m_wen = 0;
  bit          m_ovf = 0;
  logic [31:0] m_data = '0;
  bit          m_wide_at_beat = 0;
  int          sz;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q.delete(); m_half = 0; m_wen = 0; m_ovf = 0;
    end else begin
      sz = q.size();
      m_wen = bus_ack && (sz > 0);
      if (m_wen) begin
        m_wide_at_beat = wide_mode;
        if (wide_mode) begin
          m_data = q.pop_front();
        end else if (!m_half) begin
          m_data = {16'h0, q[0][15:0]};
          m_half = 1;
        end else begin
          m_data = {16'h0, q[0][31:16]};
          void'(q.pop_front());
          m_half = 0;
        end
      end
      if (wr_en) begin
        if (sz >= DEPTH) m_ovf = 1;
        else q.push_back(wr_data);
      end
    end
  end

  always @(negedge clk) begin
    if (live && rst_n) begin
      chk(bus_wen === m_wen, "R5 R10 wen", {31'h0, bus_wen}, {31'h0, m_wen});
      chk(bus_req === (q.size() != 0), "R2 req", {31'h0, bus_req}, {31'h0, q.size() != 0});
      chk(empty === (q.size() == 0), "R2 empty", {31'h0, empty}, {31'h0, q.size() == 0});
      chk(full === (q.size() == DEPTH), "R4 full", {31'h0, full}, {31'h0, q.size() == DEPTH});
      chk(overflow === m_ovf, "R3 overflow", {31'h0, overflow}, {31'h0, m_ovf});
      chk(bus_clk === 1'b0, "R11 bus_clk", {31'h0, bus_clk}, 32'h0);
      if (m_wen) begin
        if (m_wide_at_beat) chk(bus_data === m_data, "R8 R9 data", bus_data, m_data);
        else                chk(bus_data === m_data, "R6 R7 R9 data", bus_data, m_data);
      end
    end
  end

  task automatic step(input bit w, input logic [31:0] d, input bit a);
    @(negedge clk);
    wr_en = w; wr_data = d; bus_ack = a;
  endtask

  task automatic drain();
    bus_ack = 1'b1; wr_en = 1'b0;
    for (int i = 0; i < 3000 && !(empty && !bus_wen); i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    wait (cycles > 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
    finish_run();
  end

  logic [15:0] lf = 16'hace1;

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_req && !bus_wen && empty && !full && !overflow, "R1 reset",
        {27'h0, bus_req, bus_wen, empty, full, overflow}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && !bus_wen && empty && !full && !overflow, "R1 after reset",
        {27'h0, bus_req, bus_wen, empty, full, overflow}, 32'h4);
    live = 1;

    // R6 R10: narrow, ack held high
    step(1, 32'h1111_AAAA, 1);
    step(1, 32'h2222_BBBB, 1);
    step(1, 32'h3333_CCCC, 1);
    drain();

    // R7: ack drops between the two halves
    step(1, 32'hDEAD_BEEF, 0);
    step(1, 32'hCAFE_F00D, 0);
    step(0, 0, 1);
    step(0, 0, 0);
    step(0, 0, 0);
    step(0, 0, 1);
    step(0, 0, 0);
    step(0, 0, 1);
    step(0, 0, 0);
    drain();

    // R3 R4: fill with ack low, then drop extra writes
    for (int i = 0; i < DEPTH; i++) step(1, 32'h5000_0000 + i, 0);
    step(1, 32'hBAD0_0001, 0);
    step(1, 32'hBAD0_0002, 0);
    step(0, 0, 0);
    step(0, 0, 0);
    drain();

    // R8: wide mode, after draining
    wide_mode = 1'b1;
    step(1, 32'h0123_4567, 1);
    step(1, 32'h89AB_CDEF, 0);
    step(1, 32'hFEDC_BA98, 1);
    step(0, 0, 0);
    drain();

    // R9: pseudo-random traffic in both modes
    for (int pass = 0; pass < 2; pass++) begin
      wide_mode = (pass == 1);
      for (int i = 0; i < 1500; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        step(lf[0] & lf[3], {lf, ~lf} ^ i, lf[5] | lf[8]);
      end
      drain();
    end

    finish_run();
  end
endmodule